// File: doc/BRIEF.md
# Stream Identifier Span Matcher

This block decides whether one event passes a counter's stream filter. Each cycle it may receive a stream identifier together with a valid strobe. It compares that identifier against a programmed pattern and a one-bit span mode. It reports the verdict as a registered flag one clock after the strobe. Choosing which counter's pattern applies, and the counting itself, belong to the logic around it.

With span mode off, the identifier must equal the pattern bit for bit. With span mode on, the pattern also carries the width of a don't-care field at its low end. That field is a run of ones ended by the lowest zero bit of the pattern. The zero bit and every bit below it are ignored in the identifier, and every bit above the zero must match. For example, a pattern of 0x42 accepts identifiers 0x42 and 0x43. A pattern of all ones has no zero bit, so in span mode it accepts every identifier, which gives an unfiltered counter.

Top module: `sid_span_match`

## Requirements
- R1: With span mode 0 (`span_en`=0), a valid identifier equal to `pattern` gives `match_o`=1 one cycle later.
- R2: With span mode 0, a valid identifier that differs from `pattern` in any bit gives `match_o`=0 one cycle later.
- R3: With span mode 1, when the lowest zero bit of `pattern` sits at position Y-1, identifier bits Y-1 down to 0 are ignored. Any values there still give a match when the upper bits agree.
- R4: With span mode 1, a difference in any identifier bit at position Y or above gives `match_o`=0 one cycle later.
- R5: With span mode 1 and `pattern`=0x42, exactly the identifiers 0x42 and 0x43 match.
- R6: With span mode 1 and `pattern` all ones, every valid identifier matches.
- R7: With span mode 1 and `pattern` bit 0 equal to 0, only identifier bit 0 is ignored, and bits 31:1 must equal the pattern.
- R8: `match_o` is 1 only in the cycle after a cycle with `id_vld`=1. When the strobe is low, the identifier and pattern have no effect and `match_o` is 0 one cycle later.
- R9: `match_o` is 0 while `rst_n` is low and in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pattern | input | ID_W | Programmed filter pattern; in span mode its trailing ones and first zero select the ignored low bits |
| span_en | input | 1 | 0 = exact compare, 1 = span compare |
| id_in | input | ID_W | Stream identifier of the incoming event |
| id_vld | input | 1 | Strobe qualifying `id_in` |
| match_o | output | 1 | Registered verdict for the identifier strobed in the previous cycle |

## Verification
Embedded properties watch every cycle for several rules: exact hits and misses, unconditional acceptance under an all-ones span pattern, bit-0-only masking when the pattern's bit 0 is clear, silence after an unqualified cycle, and a low flag across reset. Masks of arbitrary width, and the rejection of a difference just above the boundary, show up only in the bench's scenarios. There a separate model locates the boundary bit by bit and compares its result with the output for sweeps of boundary positions, the 0x42 neighbourhood and random patterns.

// File: rtl/sid_span_match.sv
module sid_span_match #(
  parameter int ID_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] pattern,
  input  logic            span_en,
  input  logic [ID_W-1:0] id_in,
  input  logic            id_vld,
  output logic            match_o
);

  localparam logic [ID_W-1:0] ONE = {{(ID_W-1){1'b0}}, 1'b1};

  logic [ID_W-1:0] dont_care;
  logic [ID_W-1:0] diff;
  logic            all_ones;
  logic            hit;

  // pattern ^ (pattern+1) covers the trailing ones plus the first zero
  assign all_ones  = &pattern;
  assign dont_care = span_en ? (pattern ^ (pattern + ONE)) : '0;
  assign diff      = (id_in ^ pattern) & ~dont_care;
  assign hit       = (span_en && all_ones) || (diff == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_o <= 1'b0;
    else        match_o <= id_vld & hit;
  end

  p_exact_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (id_vld && !span_en && id_in == pattern) |=> match_o);

  p_exact_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_vld && !span_en && id_in != pattern) |=> !match_o);

  p_all_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_vld && span_en && (&pattern)) |=> match_o);

  p_bit0_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_vld && span_en && !pattern[0] && id_in[ID_W-1:1] == pattern[ID_W-1:1]) |=> match_o);

  p_bit0_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_vld && span_en && !pattern[0] && id_in[ID_W-1:1] != pattern[ID_W-1:1]) |=> !match_o);

  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !id_vld |=> !match_o);

  p_reset_low_r9: assert property (@(posedge clk)
    !rst_n |=> !match_o);

endmodule

// File: tb/sim_sid_span_match.sv
module sim_sid_span_match;
  localparam int W = 32;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [W-1:0] pattern = '0;
  logic         span_en = 0;
  logic [W-1:0] id_in = '0;
  logic         id_vld = 0;
  logic         match_o;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  sid_span_match #(.ID_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pattern(pattern), .span_en(span_en),
    .id_in(id_in), .id_vld(id_vld), .match_o(match_o)
  );

  function automatic bit model(input logic [W-1:0] p, input bit s,
                               input logic [W-1:0] id);
    int zpos;
    bit ok;
    if (!s) return id == p;
    zpos = -1;
    for (int i = 0; i < W; i++)
      if (zpos < 0 && !p[i]) zpos = i;
    if (zpos < 0) return 1'b1;
    ok = 1'b1;
    for (int i = zpos + 1; i < W; i++)
      if (id[i] != p[i]) ok = 1'b0;
    return ok;
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: match_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [W-1:0] p, input bit s,
                       input logic [W-1:0] id, input bit v);
    @(negedge clk);
    pattern = p; span_en = s; id_in = id; id_vld = v;
    exp_q.push_back(v ? model(p, s, id) : 1'b0);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, match_o, e);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] p;
    repeat (3) @(negedge clk);
    check("R9 in reset", match_o, 1'b0);
    id_vld = 1; span_en = 1; pattern = '1;
    @(negedge clk);
    rst_n = 1;
    id_vld = 0;
    @(posedge clk); #1;
    check("R9 first cycle after reset", match_o, 1'b0);

    drive("R1 exact equal", 32'hDEAD_BEEF, 0, 32'hDEAD_BEEF, 1);
    drive("R1 exact zero", 32'h0, 0, 32'h0, 1);
    drive("R2 exact bit0 diff", 32'hDEAD_BEEF, 0, 32'hDEAD_BEEE, 1);
    drive("R2 exact bit31 diff", 32'h1234_5678, 0, 32'h9234_5678, 1);
    drive("R2 all-ones without span", '1, 0, 32'h0000_0001, 1);
    drive("R5 0x42", 32'h42, 1, 32'h42, 1);
    drive("R5 0x43", 32'h42, 1, 32'h43, 1);
    drive("R5 0x40", 32'h42, 1, 32'h40, 1);
    drive("R5 0x41", 32'h42, 1, 32'h41, 1);
    drive("R5 0x44", 32'h42, 1, 32'h44, 1);
    drive("R5 0xC2", 32'h42, 1, 32'hC2, 1);
    drive("R6 all ones id 0", '1, 1, 32'h0, 1);
    drive("R6 all ones id x", '1, 1, 32'h8765_4321, 1);
    drive("R7 bit0 zero low diff", 32'hA5A5_A5A4, 1, 32'hA5A5_A5A5, 1);
    drive("R7 bit0 zero bit1 diff", 32'hA5A5_A5A4, 1, 32'hA5A5_A5A6, 1);
    drive("R8 strobe low equal", 32'h77, 0, 32'h77, 0);
    drive("R8 strobe low all ones", '1, 1, 32'h5, 0);
    drive("R1 back to back", 32'h77, 0, 32'h77, 1);

    for (int y = 1; y <= W - 1; y++) begin
      p = 32'hC3A5_5A3C;
      p[y-1] = 1'b0;
      for (int b = 0; b < y - 1; b++) p[b] = 1'b1;
      drive("R3 low field ignored", p, 1, p ^ ((32'h1 << y) - 1), 1);
      drive("R4 bit above boundary", p, 1, p ^ (32'h1 << y), 1);
      drive("R4 top bit", p, 1, p ^ 32'h8000_0000, 1);
    end

    for (int k = 0; k < 200; k++) begin
      logic [W-1:0] rp, rm;
      rp = $urandom();
      rm = (32'h1 << ($urandom() % 8)) - 1;
      drive("R3 random span", rp, 1, rp ^ rm, ($urandom() % 4) != 0);
      drive("R1 random exact", rp, 0, ($urandom() % 2) ? rp : rp ^ rm, 1);
    end

    drive("R8 idle tail", 32'h0, 0, 32'h0, 0);
    @(negedge clk);
    id_vld = 0;
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule